// File: doc/BRIEF.md
# Serial GPIO Shift Controller

This block turns four pins into a large set of general-purpose lines by running a serial chain through external shift registers. The chain is organised as up to 32 ports, each port carrying one to four bits. During a frame the controller walks the enabled ports in ascending order and, inside each port, the bits in ascending order. For each bit it presents the stored output value on the data-out pin and samples the data-in pin. A one-cycle load pulse closes the frame. That pulse tells the external registers to latch their outputs, and it moves every captured input bit into the readable input words in a single step.

Software drives the block through a small write/read register port. It selects the enabled ports, the bits per port and the serial clock divider. It can start a single frame or let frames follow one another automatically. Each port has a configuration word with a 3-bit field per pin. The pin's drive value is the lowest bit of its field, at bit 3 × bit index. Input data is read back as one word per bit index, with one flag per port.

Top module: `sgpio_chain_ctrl`

## Requirements
- R1: After reset every register reads zero, and `sio_clk`, `sio_dout` and `sio_load` are low.
- R2: Port word p lives at address 0x20+p (12 bits wide, read back as written). The drive value of pin (p, b) is bit 3·b of that word.
- R3: A frame shifts one bit per serial clock period. Enabled ports go in ascending order and bits within a port go in ascending order. Ports whose bit in the enable mask (address 0x04) is clear are skipped.
- R4: The width field, control bits [1:0] at address 0x05, holds bits-per-port minus one. A frame carries exactly (enabled ports) × (field + 1) bits.
- R5: The serial clock period is D system cycles, where D is the divider (address 0x06) or 2 if the divider is below 2. Each period is low for floor(D/2) cycles, then high for the rest.
- R6: `sio_dout` changes only while `sio_clk` is low: at a falling edge, at frame start, or at frame end. `sio_din` is sampled at the system edge on which `sio_clk` rises.
- R7: `sio_load` is high for exactly one cycle after the last bit, with `sio_clk` low. The input words change only at the end of that cycle.
- R8: Input word b is at address b (0..3). Its bit p is the value sampled for port p, bit b. Bits for disabled ports and for bit indices at or above the width read 0.
- R9: Writing control with bit 3 set starts one frame from idle. Control bit 2 (auto-repeat) starts a new frame one idle cycle after each load pulse, so consecutive loads are N·D+2 cycles apart for N bits. With auto-repeat clear the controller stays idle after the load.
- R10: The enable mask, width and divider are captured at frame start. Writes to them during a frame, and writes to port words during a bit, do not disturb that frame or bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| sio_clk | output | 1 | Serial chain clock |
| sio_dout | output | 1 | Serial data toward the chain |
| sio_load | output | 1 | End-of-frame load strobe |
| sio_din | input | 1 | Serial data returning from the chain |

## Verification
The assertions take for granted that `sio_din` and the register inputs are known values at every clock edge. They also assume the frame parameters are only changed through the register port, so the captured divider is always a clamped value. The stimulus respects this by driving all inputs at the falling system edge. `sio_din` is fed back from `sio_dout`, optionally inverted, so every sampled bit has a known expected value. Frame-starting control writes are issued only after the width has been programmed by a separate write, because the start captures the width held before that edge.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_LOAD  = 2'd2
   } seq_state_e;

   // register map
   localparam int ADDR_IN_BASE   = 0;
   localparam int ADDR_ENABLE    = 4;
   localparam int ADDR_CTRL      = 5;
   localparam int ADDR_DIV       = 6;
   localparam int ADDR_PORT_BASE = 32;

   // control word bit positions (width field sits at the bottom)
   localparam int CTRL_AUTO_POS  = 2;
   localparam int CTRL_GO_POS    = 3;

   function automatic int clog2_min1(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/sgc_sclk_gen.sv
module sgc_sclk_gen #(
   parameter int DIVW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] div,
   output logic            sclk,
   output logic            sample_pt,
   output logic            bit_end
);

   logic [DIVW-1:0] cnt_q;
   logic [DIVW-1:0] half;
   logic [DIVW-1:0] last;

   assign half = div >> 1;
   assign last = div - DIVW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q == last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIVW'(1);
      end
   end

   assign sclk      = run && (cnt_q >= half);
   assign sample_pt = run && (cnt_q == half - DIVW'(1));
   assign bit_end   = run && (cnt_q == last);

   // the sequencer must hand over a clamped divider
   assert_div_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (div >= DIVW'(2)));

endmodule

// File: rtl/sgc_regfile.sv
module sgc_regfile
   import sgc_pkg::*;
#(
   parameter int NPORTS = 32,
   parameter int MAXB   = 4,
   parameter int FIELDW = 3,
   parameter int DIVW   = 12,
   parameter int AW     = 8,
   parameter int PW     = clog2_min1(NPORTS),
   parameter int BW     = clog2_min1(MAXB)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [AW-1:0]          addr,
   input  logic [31:0]            wdata,
   output logic [31:0]            rdata,
   output logic [NPORTS-1:0]      en_mask,
   output logic [BW-1:0]          width_f,
   output logic                   auto_rep,
   output logic                   go,
   output logic [DIVW-1:0]        div_raw,
   output logic [NPORTS*MAXB-1:0] out_bits,
   input  logic                   cap_clr,
   input  logic                   cap_en,
   input  logic [PW-1:0]          cap_port,
   input  logic [BW-1:0]          cap_bit,
   input  logic                   cap_val,
   input  logic                   load
);

   localparam int FW = FIELDW * MAXB;

   logic [NPORTS-1:0][FW-1:0]     port_q;
   logic [MAXB-1:0][NPORTS-1:0]   cap_q;
   logic [MAXB-1:0][NPORTS-1:0]   in_q;
   logic [BW-1:0]                 wf_in;

   assign go    = we && (addr == AW'(ADDR_CTRL)) && wdata[CTRL_GO_POS];
   assign wf_in = (int'(wdata[BW-1:0]) > MAXB - 1) ? BW'(MAXB - 1) : wdata[BW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask  <= '0;
         width_f  <= '0;
         auto_rep <= 1'b0;
         div_raw  <= '0;
      end else if (we) begin
         if (addr == AW'(ADDR_ENABLE)) en_mask <= wdata[NPORTS-1:0];
         if (addr == AW'(ADDR_CTRL)) begin
            width_f  <= wf_in;
            auto_rep <= wdata[CTRL_AUTO_POS];
         end
         if (addr == AW'(ADDR_DIV)) div_raw <= wdata[DIVW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '0;
      end else if (we) begin
         for (int p = 0; p < NPORTS; p++) begin
            if (addr == AW'(ADDR_PORT_BASE + p)) port_q[p] <= wdata[FW-1:0];
         end
      end
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      for (genvar b = 0; b < MAXB; b++) begin : g_pin
         assign out_bits[p*MAXB + b] = port_q[p][FIELDW*b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (cap_clr) begin
         cap_q <= '0;
      end else if (cap_en) begin
         cap_q[cap_bit][cap_port] <= cap_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q <= '0;
      end else if (load) begin
         in_q <= cap_q;
      end
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < MAXB; b++) begin
         if (addr == AW'(ADDR_IN_BASE + b)) rdata = 32'(in_q[b]);
      end
      if (addr == AW'(ADDR_ENABLE)) rdata = 32'(en_mask);
      if (addr == AW'(ADDR_CTRL)) begin
         rdata[BW-1:0]         = width_f;
         rdata[CTRL_AUTO_POS]  = auto_rep;
      end
      if (addr == AW'(ADDR_DIV)) rdata = 32'(div_raw);
      for (int p = 0; p < NPORTS; p++) begin
         if (addr == AW'(ADDR_PORT_BASE + p)) rdata = 32'(port_q[p]);
      end
   end

   // input words move only with the load strobe
   assert_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(in_q));

endmodule

// File: rtl/sgc_frame_seq.sv
module sgc_frame_seq
   import sgc_pkg::*;
#(
   parameter int NPORTS = 32,
   parameter int MAXB   = 4,
   parameter int DIVW   = 12,
   parameter int PW     = clog2_min1(NPORTS),
   parameter int BW     = clog2_min1(MAXB)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic                   auto_rep,
   input  logic [NPORTS-1:0]      en_mask,
   input  logic [BW-1:0]          width_f,
   input  logic [DIVW-1:0]        div_raw,
   input  logic [NPORTS*MAXB-1:0] out_bits,
   input  logic                   bit_end,
   input  logic                   sample_pt,
   input  logic                   sdi,
   output logic                   run,
   output logic                   sdo,
   output logic                   load,
   output logic [DIVW-1:0]        div_q,
   output logic                   cap_clr,
   output logic                   cap_en,
   output logic [PW-1:0]          cap_port,
   output logic [BW-1:0]          cap_bit,
   output logic                   cap_val
);

   seq_state_e          st_q;
   logic [PW-1:0]       cur_p;
   logic [BW-1:0]       cur_b;
   logic [NPORTS-1:0]   mask_q;
   logic [BW-1:0]       wid_q;
   logic                sdo_q;
   logic [PW:0]         first_r;
   logic [PW:0]         next_r;
   logic                start;
   logic [DIVW-1:0]     div_eff;

   // lowest enabled port at or above base: {found, index}
   function automatic logic [PW:0] find_from(input logic [NPORTS-1:0] m, input int base);
      logic [PW:0] r;
      r = '0;
      for (int i = NPORTS - 1; i >= 0; i--) begin
         if (i >= base && m[i]) r = {1'b1, PW'(i)};
      end
      return r;
   endfunction

   function automatic int pin_idx(input logic [PW-1:0] p, input int b);
      return int'(p) * MAXB + b;
   endfunction

   assign first_r = find_from(en_mask, 0);
   assign next_r  = find_from(mask_q, int'(cur_p) + 1);
   assign start   = (st_q == SEQ_IDLE) && (go || auto_rep);
   assign div_eff = (div_raw < DIVW'(2)) ? DIVW'(2) : div_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         cur_p  <= '0;
         cur_b  <= '0;
         mask_q <= '0;
         wid_q  <= '0;
         div_q  <= DIVW'(2);
         sdo_q  <= 1'b0;
      end else begin
         case (st_q)
            SEQ_IDLE: begin
               if (start) begin
                  mask_q <= en_mask;
                  wid_q  <= width_f;
                  div_q  <= div_eff;
                  cur_b  <= '0;
                  if (first_r[PW]) begin
                     st_q  <= SEQ_SHIFT;
                     cur_p <= first_r[PW-1:0];
                     sdo_q <= out_bits[pin_idx(first_r[PW-1:0], 0)];
                  end else begin
                     st_q  <= SEQ_LOAD;
                  end
               end
            end
            SEQ_SHIFT: begin
               if (bit_end) begin
                  if (cur_b < wid_q) begin
                     cur_b <= cur_b + 1'b1;
                     sdo_q <= out_bits[pin_idx(cur_p, int'(cur_b) + 1)];
                  end else if (next_r[PW]) begin
                     cur_p <= next_r[PW-1:0];
                     cur_b <= '0;
                     sdo_q <= out_bits[pin_idx(next_r[PW-1:0], 0)];
                  end else begin
                     st_q  <= SEQ_LOAD;
                     sdo_q <= 1'b0;
                  end
               end
            end
            SEQ_LOAD: begin
               st_q <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign run      = (st_q == SEQ_SHIFT);
   assign load     = (st_q == SEQ_LOAD);
   assign sdo      = sdo_q;
   assign cap_clr  = start;
   assign cap_en   = run && sample_pt;
   assign cap_port = cur_p;
   assign cap_bit  = cur_b;
   assign cap_val  = sdi;

   // the port being shifted was enabled when the frame began
   assert_port_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> mask_q[cur_p]);

   // a load is always followed by an idle cycle
   assert_load_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (st_q == SEQ_IDLE));

endmodule

// File: rtl/sgpio_chain_ctrl.sv
module sgpio_chain_ctrl
   import sgc_pkg::*;
#(
   parameter int NPORTS = 32,
   parameter int MAXB   = 4,
   parameter int FIELDW = 3,
   parameter int DIVW   = 12,
   parameter int AW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          sio_clk,
   output logic          sio_dout,
   output logic          sio_load,
   input  logic          sio_din
);

   localparam int PW = clog2_min1(NPORTS);
   localparam int BW = clog2_min1(MAXB);

   if (NPORTS < 1 || NPORTS > 32) begin : g_bad_ports
      $error("NPORTS must be 1..32");
   end
   if (MAXB < 1 || MAXB > 4) begin : g_bad_bits
      $error("MAXB must be 1..4");
   end
   if (FIELDW < 1 || FIELDW * MAXB > 32) begin : g_bad_field
      $error("port word must fit 32 bits");
   end
   if (DIVW < 2 || DIVW > 32) begin : g_bad_div
      $error("DIVW must be 2..32");
   end
   if (AW < 6) begin : g_bad_addr
      $error("AW too small for port words");
   end

   logic [NPORTS-1:0]      en_mask;
   logic [BW-1:0]          width_f;
   logic                   auto_rep;
   logic                   go;
   logic [DIVW-1:0]        div_raw;
   logic [DIVW-1:0]        div_q;
   logic [NPORTS*MAXB-1:0] out_bits;
   logic                   run;
   logic                   bit_end;
   logic                   sample_pt;
   logic                   cap_clr;
   logic                   cap_en;
   logic [PW-1:0]          cap_port;
   logic [BW-1:0]          cap_bit;
   logic                   cap_val;

   sgc_regfile #(
      .NPORTS(NPORTS), .MAXB(MAXB), .FIELDW(FIELDW), .DIVW(DIVW),
      .AW(AW), .PW(PW), .BW(BW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .en_mask(en_mask), .width_f(width_f), .auto_rep(auto_rep),
      .go(go), .div_raw(div_raw), .out_bits(out_bits), .cap_clr(cap_clr),
      .cap_en(cap_en), .cap_port(cap_port), .cap_bit(cap_bit), .cap_val(cap_val),
      .load(sio_load)
   );

   sgc_frame_seq #(
      .NPORTS(NPORTS), .MAXB(MAXB), .DIVW(DIVW), .PW(PW), .BW(BW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .auto_rep(auto_rep), .en_mask(en_mask),
      .width_f(width_f), .div_raw(div_raw), .out_bits(out_bits), .bit_end(bit_end),
      .sample_pt(sample_pt), .sdi(sio_din), .run(run), .sdo(sio_dout),
      .load(sio_load), .div_q(div_q), .cap_clr(cap_clr), .cap_en(cap_en),
      .cap_port(cap_port), .cap_bit(cap_bit), .cap_val(cap_val)
   );

   sgc_sclk_gen #(
      .DIVW(DIVW)
   ) u_sclk (
      .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .sclk(sio_clk),
      .sample_pt(sample_pt), .bit_end(bit_end)
   );

   assert_dout_low_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sio_dout) |-> !sio_clk);

   assert_load_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sio_load |=> !sio_load);

   assert_load_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sio_load |-> !sio_clk);

endmodule

// File: tb/sgpio_chain_ctrl_test.sv
`timescale 1ns/1ps
module sgpio_chain_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        sio_clk, sio_dout, sio_load, sio_din;
   logic        inv = 1'b0;

   always #4 clk = ~clk;
   assign sio_din = sio_dout ^ inv;

   sgpio_chain_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sio_clk(sio_clk),
      .sio_dout(sio_dout), .sio_load(sio_load), .sio_din(sio_din)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // model of the programmed state
   logic [11:0] m_word [32];
   logic [31:0] m_en = '0;
   int          m_wf = 0;
   int          m_div = 0;
   int          exp_div = 2;
   logic [31:0] prev_in0 = '0;

   // monitor state
   bit     prev_sclk = 0, prev_load = 0, prev_dout = 0, have_fall = 0;
   int     run_len = 0, n_seen = 0, loads = 0, sclk_high = 0;
   bit     seen [256];
   longint cyc = 0, last_load = 0, gap = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sio_dout != prev_dout) chk(!sio_clk, "R6 dout moved with clock high", 1, 0);
         if (sio_clk && !prev_sclk) begin
            if (n_seen < 256) seen[n_seen] = sio_dout;
            n_seen++;
            if (have_fall) chk(run_len == exp_div/2, "R5 low phase", run_len, exp_div/2);
            run_len = 1;
         end else if (!sio_clk && prev_sclk) begin
            chk(run_len == exp_div - exp_div/2, "R5 high phase", run_len, exp_div - exp_div/2);
            have_fall = 1;
            run_len = 1;
         end else begin
            run_len++;
         end
         if (sio_clk) sclk_high++;
         if (sio_load) begin
            if (prev_load) chk(0, "R7 load wider than one cycle", 2, 1);
            have_fall = 0;
            loads++;
            gap = cyc - last_load;
            last_load = cyc;
         end
         prev_load = sio_load;
         prev_sclk = sio_clk;
         prev_dout = sio_dout;
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 8'(a);
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] exp_in(input int b);
      logic [31:0] r = '0;
      for (int p = 0; p < 32; p++)
         if (m_en[p] && b <= m_wf) r[p] = m_word[p][3*b] ^ inv;
      return r;
   endfunction

   task automatic program_cfg();
      wr(4, m_en);
      wr(5, 32'(m_wf));
      wr(6, 32'(m_div));
      for (int p = 0; p < 32; p++) wr(32 + p, 32'(m_word[p]));
      exp_div = (m_div < 2) ? 2 : m_div;
   endtask

   task automatic run_frame(input string tag);
      bit          e [256];
      int          k = 0;
      int          l0;
      int          t = 0;
      logic [31:0] d;
      for (int p = 0; p < 32; p++)
         for (int b = 0; b <= m_wf; b++)
            if (m_en[p]) begin e[k] = m_word[p][3*b]; k++; end
      n_seen = 0;
      l0 = loads;
      wr(5, 32'(m_wf) | 32'h8);
      #1;
      if (k > 1) begin
         rd(0, d);
         chk(d == prev_in0, {"R7 input word changed before load ", tag}, d, prev_in0);
      end
      while (loads == l0 && t < 5000) begin @(negedge clk); #1; t++; end
      chk(n_seen == k, {"R3 R4 bit count ", tag}, n_seen, k);
      for (int i = 0; i < k && i < n_seen; i++)
         chk(seen[i] == e[i], {"R2 R3 serial bit ", tag}, seen[i], e[i]);
      for (int b = 0; b < 4; b++) begin
         rd(b, d);
         chk(d == exp_in(b), {"R6 R8 input word ", tag}, d, exp_in(b));
      end
      prev_in0 = exp_in(0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int l0, h0;
      void'($urandom(32'd4711));
      for (int p = 0; p < 32; p++) m_word[p] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(!sio_clk && !sio_dout && !sio_load, "R1 pins after reset",
          {sio_clk, sio_dout, sio_load}, 0);
      for (int a = 0; a < 7; a++) begin
         rd(a, d); chk(d == 0, "R1 register reset", d, 0);
      end
      for (int p = 0; p < 32; p += 7) begin
         rd(32 + p, d); chk(d == 0, "R1 port word reset", d, 0);
      end

      // directed: every port, four bits, fastest clock
      m_en = 32'hFFFF_FFFF; m_wf = 3; m_div = 2;
      for (int p = 0; p < 32; p++) m_word[p] = 12'($urandom);
      program_cfg();
      rd(32 + 5, d); chk(d == 32'(m_word[5]), "R2 port word readback", d, m_word[5]);
      rd(5, d); chk(d == 32'd3, "R4 width readback", d, 3);
      run_frame("all ports");

      // directed: last port only, inverted return, odd divider
      m_en = 32'h8000_0000; m_wf = 3; m_div = 5; inv = 1'b1;
      program_cfg();
      run_frame("port 31");

      // directed: port 0 only, one bit, divider 0 clamps to 2
      m_en = 32'h1; m_wf = 0; m_div = 0; inv = 1'b0;
      program_cfg();
      run_frame("divider 0");

      // directed: divider 1 clamps to 2, sparse ports (R5)
      m_en = 32'h4000_0102; m_wf = 1; m_div = 1;
      program_cfg();
      run_frame("divider 1");

      // directed: empty mask, all inputs read zero (R8)
      m_en = 32'h0; m_wf = 2; m_div = 3;
      program_cfg();
      run_frame("empty mask");

      // random frames
      for (int it = 0; it < 8; it++) begin
         m_en  = $urandom & $urandom;
         m_wf  = int'($urandom % 4);
         m_div = int'($urandom % 6);
         inv   = 1'($urandom);
         for (int p = 0; p < 32; p++) m_word[p] = 12'($urandom);
         program_cfg();
         run_frame("random");
      end

      // R10: a capture-time change mid frame does not disturb the frame
      m_en = 32'h0000_00F0; m_wf = 2; m_div = 4; inv = 1'b0;
      program_cfg();
      n_seen = 0; l0 = loads;
      wr(5, 32'(m_wf) | 32'h8);
      wr(4, 32'h0000_0001);
      wr(6, 32'd2);
      wr(5, 32'd0);
      while (loads == l0) begin @(negedge clk); #1; end
      chk(n_seen == 12, "R10 frame kept captured setup", n_seen, 12);
      m_en = 32'h1; m_div = 2; m_wf = 0;

      // R9: auto-repeat spacing
      m_en = 32'h0000_0811; m_wf = 1; m_div = 3;
      program_cfg();
      l0 = loads;
      wr(5, 32'h4 | 32'(m_wf));
      while (loads < l0 + 3) begin @(negedge clk); #1; end
      chk(gap == 6*3 + 2, "R9 auto-repeat spacing", gap, 20);
      wr(5, 32'(m_wf));
      repeat (800) @(negedge clk);
      #1 l0 = loads; h0 = sclk_high;
      repeat (300) @(negedge clk);
      #1;
      chk(loads == l0, "R9 idle after auto cleared", loads - l0, 0);
      chk(sclk_high == h0, "R9 clock quiet when idle", sclk_high - h0, 0);

      // R9: auto-repeat with nothing enabled
      m_en = 32'h0;
      wr(4, m_en);
      l0 = loads;
      wr(5, 32'h4);
      while (loads < l0 + 3) begin @(negedge clk); #1; end
      chk(gap == 2, "R9 empty-frame spacing", gap, 2);
      wr(5, 32'h0);
      repeat (20) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule